// File: doc/BRIEF.md
# Mode-Programmable Parallel Port with Service-Request Handshake

This block is an 8-bit parallel port. A mode pin makes it either an input port or an output port. In input mode a peripheral strobes a byte into the data register. The service-request output then goes low to report that data is waiting. The host reads the byte by selecting the port with both chip selects. Deselecting the port floats the bus and releases the request.

In output mode the host writes the register through the selects and the strobe, and the data bus is driven at all times. Each time the port is deselected, the service-request output rises to tell the peripheral that new data is present. The next falling strobe drops it again.

The strobe and both chip selects are asynchronous to the free-running system clock, so each passes through a synchronizer first. The three-state bus is modelled as a data vector plus a separate drive-enable output. An asynchronous clear empties the register and puts the request flag in its idle level. That level is high in input mode and low in output mode.

Top module: `hs_port`

## Requirements
- R1: `mode_i` (0 = input port, 1 = output port) is sampled on the first clock edge after `rst_ni` or `clear_i` is released. Later changes of `mode_i` have no effect until the next clear or reset. While clear or reset is asserted, the pin value applies directly.
- R2: In input mode the register follows `din_i` while the synchronized strobe is high. It keeps the last value once the strobe has fallen, whatever `din_i` does afterwards.
- R3: In input mode a falling strobe drives `srq_o` low (data ready).
- R4: In input mode `dout_en_o` is 1 only while `cs1_i` and `cs2_i` are both high. `dout_o` shows the register when enabled and reads 0 when not.
- R5: In input mode, the port leaving the selected state drives `srq_o` high. If a strobe fall is detected in the same cycle, `srq_o` goes low instead.
- R6: In output mode `dout_en_o` is always 1 and `dout_o` shows the register.
- R7: In output mode the register loads `din_i` only while `cs1_i` is low, `cs2_i` is high and the strobe is high. At all other times it holds its value.
- R8: In output mode `srq_o` goes high on the first cycle of deselection (`cs1_i` high or `cs2_i` low). It goes low on the next strobe fall. When both are detected in the same cycle, it goes low.
- R9: `clear_i` (active high, asynchronous) forces the register to 0 and `srq_o` to 1 in input mode or 0 in output mode. It overrides any strobe activity. Reset `rst_ni` behaves the same way.
- R10: Strobe and chip selects pass through a two-flop synchronizer, so `srq_o` responds on the third rising clock edge after the strobe falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clear_i | input | 1 | Asynchronous active-high port clear |
| mode_i | input | 1 | 0 input port, 1 output port |
| strobe_i | input | 1 | Asynchronous data strobe |
| cs1_i | input | 1 | Chip select 1 (high selects in input mode, low in output mode) |
| cs2_i | input | 1 | Chip select 2, active high |
| din_i | input | 8 | Data in |
| dout_o | output | 8 | Data out, 0 when not driven |
| dout_en_o | output | 1 | Bus drive enable (0 = high impedance) |
| srq_o | output | 1 | Service request |

## Verification
The bench targets a strobe fall that arrives in the same cycle as a deselect, in both modes. Input mode must keep the request low and output mode must pull it low. A design that ranks these two events the wrong way leaves the request at the wrong level.

It also changes the mode pin without a clear. A port that switches mode at once would start or stop driving the bus, and that shows on `dout_en_o`.

Output-mode strobes sent while the port is deselected must leave the register untouched. A clear asserted while the strobe is high must still empty the register. A directed edge count checks that the request changes on exactly the third clock after a strobe falls, so a missing or extra synchronizer stage is caught.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    MODE_IN  = 1'b0,
    MODE_OUT = 1'b1
  } port_mode_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni || clr_i) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/hs_datareg.sv
module hs_datareg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni || clr_i) q_o <= '0;
    else if (load_i)      q_o <= d_i;
  end

  a_r7_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !load_i |=> $stable(q_o));

  a_r9_clear_zeroes_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (q_o == '0));
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  port_mode_e mode_i,
  input  logic       stb_s_i,
  input  logic       cs1_s_i,
  input  logic       cs2_s_i,
  output logic       sel_o,
  output logic       load_o,
  output logic       srq_o
);
  logic stb_d, sel_d, flag_q;
  logic fall, drop;

  // selection polarity of cs1 flips with mode
  always_comb begin
    if (mode_i == MODE_OUT) sel_o = !cs1_s_i && cs2_s_i;
    else                    sel_o = cs1_s_i && cs2_s_i;
  end

  assign load_o = (mode_i == MODE_OUT) ? (stb_s_i && sel_o) : stb_s_i;
  assign fall   = stb_d && !stb_s_i;
  assign drop   = sel_d && !sel_o;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni || clr_i) begin
      stb_d <= 1'b0;
      sel_d <= 1'b0;
    end else begin
      stb_d <= stb_s_i;
      sel_d <= sel_o;
    end
  end

  // flag: input mode = data waiting, output mode = request raised
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni || clr_i) flag_q <= 1'b0;
    else if (mode_i == MODE_OUT) begin
      if (fall)      flag_q <= 1'b0;
      else if (drop) flag_q <= 1'b1;
    end else begin
      if (fall)      flag_q <= 1'b1;
      else if (drop) flag_q <= 1'b0;
    end
  end

  assign srq_o = (mode_i == MODE_OUT) ? flag_q : !flag_q;

  a_r3_in_fall_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (mode_i == MODE_IN && fall) |=> !srq_o);

  a_r5_in_drop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (mode_i == MODE_IN && drop && !fall) |=> srq_o);

  a_r8_out_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (mode_i == MODE_OUT && fall) |=> !srq_o);

  a_r8_out_desel_sets: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (mode_i == MODE_OUT && drop && !fall) |=> srq_o);

  a_r9_clear_idles_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !flag_q);
endmodule

// File: rtl/hs_port.sv
module hs_port
  import hs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          mode_i,
  input  logic          strobe_i,
  input  logic          cs1_i,
  input  logic          cs2_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic          srq_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] async_in, sync_out;
  logic             arm_q;
  port_mode_e       mode_q, mode_eff;
  logic             sel, load;
  logic [DW-1:0]    reg_q;

  // mode is captured once after each clear/reset
  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni || clear_i) begin
      arm_q  <= 1'b1;
      mode_q <= MODE_IN;
    end else if (arm_q) begin
      arm_q  <= 1'b0;
      mode_q <= port_mode_e'(mode_i);
    end
  end

  assign mode_eff = arm_q ? port_mode_e'(mode_i) : mode_q;
  assign async_in = {cs2_i, cs1_i, strobe_i};

  hs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .d_i    (async_in),
    .q_o    (sync_out)
  );

  hs_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .mode_i  (mode_eff),
    .stb_s_i (sync_out[0]),
    .cs1_s_i (sync_out[1]),
    .cs2_s_i (sync_out[2]),
    .sel_o   (sel),
    .load_o  (load),
    .srq_o   (srq_o)
  );

  hs_datareg #(.DW(DW)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .load_i (load),
    .d_i    (din_i),
    .q_o    (reg_q)
  );

  assign dout_en_o = (mode_eff == MODE_OUT) || sel;
  assign dout_o    = dout_en_o ? reg_q : '0;

  a_r1_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    !arm_q |=> $stable(dout_en_o) || $changed(sync_out[2:1]) || $past(mode_eff == MODE_IN));

  a_r6_out_always_driven: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (!arm_q && mode_q == MODE_OUT) |-> dout_en_o);
endmodule

// File: tb/tb_hs_port.sv
module tb_hs_port;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, clear, mode, stb, cs1, cs2;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic dout_en, srq;

  int total = 0;
  int bad   = 0;

  bit m_mode, m_flag, m_psel;
  logic [DW-1:0] m_data;

  always #5 clk = ~clk;

  hs_port #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .mode_i(mode),
    .strobe_i(stb), .cs1_i(cs1), .cs2_i(cs2), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en), .srq_o(srq)
  );

  function automatic bit fsel(bit md, bit c1, bit c2);
    return md ? (!c1 && c2) : (c1 && c2);
  endfunction

  function automatic bit exp_en();
    return m_mode || fsel(m_mode, cs1, cs2);
  endfunction

  function automatic logic [DW-1:0] exp_dout();
    return exp_en() ? m_data : '0;
  endfunction

  function automatic bit exp_srq();
    return m_mode ? m_flag : !m_flag;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk({req, " en"},   32'(dout_en), 32'(exp_en()));
    chk({req, " dout"}, 32'(dout),    32'(exp_dout()));
    chk({req, " srq"},  32'(srq),     32'(exp_srq()));
  endtask

  task automatic do_cs(bit c1, bit c2);
    bit ns;
    ns = fsel(m_mode, c1, c2);
    if (m_psel && !ns) m_flag = 1'b1 ^ !m_mode ? 1'b1 : 1'b0;
    if (m_psel && !ns) m_flag = m_mode ? 1'b1 : 1'b0;
    cs1 = c1; cs2 = c2; m_psel = ns;
    wt(6);
  endtask

  task automatic do_strobe(logic [DW-1:0] d, bit chg, bit c1, bit c2);
    bit ns;
    din = d; stb = 1'b1;
    wt(5);
    if (!m_mode || m_psel) m_data = d;
    stb = 1'b0;
    if (chg) begin cs1 = c1; cs2 = c2; end
    ns = fsel(m_mode, cs1, cs2);
    m_flag = m_mode ? 1'b0 : 1'b1;  // fall dominates any same-cycle deselect
    m_psel = ns;
    wt(6);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    wt(1);
    chk("R9 clr en",   32'(dout_en), 32'(mode));
    chk("R9 clr dout", 32'(dout),    32'd0);
    chk("R9 clr srq",  32'(srq),     32'(!mode));
    clear = 1'b0;
    m_mode = mode; m_data = '0; m_flag = 1'b0;
    m_psel = fsel(m_mode, cs1, cs2);
    wt(6);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1852));
    rst_n = 1'b0; clear = 1'b0; mode = 1'b0; stb = 1'b0;
    cs1 = 1'b0; cs2 = 1'b0; din = '0;
    m_mode = 1'b0; m_flag = 1'b0; m_data = '0; m_psel = 1'b0;
    wt(2);
    // R9 reset state
    chk("R9 rst en",   32'(dout_en), 32'd0);
    chk("R9 rst srq",  32'(srq),     32'd1);
    chk("R9 rst dout", 32'(dout),    32'd0);
    rst_n = 1'b1;
    wt(6);
    check_all("R9 after rst");

    // R2/R4: follow while strobe high, hold after fall
    do_cs(1'b1, 1'b1);
    din = 8'hA5; stb = 1'b1; wt(5);
    chk("R2 follow1", 32'(dout), 32'hA5);
    din = 8'h3C; wt(5);
    chk("R2 follow2", 32'(dout), 32'h3C);
    stb = 1'b0; wt(6);
    din = 8'hFF; wt(6);
    m_data = 8'h3C; m_flag = 1'b1;
    chk("R2 hold", 32'(dout), 32'h3C);
    chk("R3 ready", 32'(srq), 32'd0);
    check_all("R4 selected");

    // R5/R4 deselect releases request and floats bus
    do_cs(1'b0, 1'b1);
    chk("R5 drop srq", 32'(srq), 32'd1);
    chk("R4 float", 32'(dout_en), 32'd0);
    check_all("R5");

    // R10 exact latency
    din = 8'h5A; stb = 1'b1; wt(5);
    stb = 1'b0;
    wt(2);
    chk("R10 early", 32'(srq), 32'd1);
    wt(1);
    chk("R10 third edge", 32'(srq), 32'd0);
    m_data = 8'h5A; m_flag = 1'b1;
    wt(3);
    check_all("R10");

    // R5 simultaneous fall and deselect: stays low
    do_cs(1'b1, 1'b1);
    do_strobe(8'h77, 1'b1, 1'b0, 1'b0);
    chk("R5 same cycle", 32'(srq), 32'd0);
    check_all("R5 same");

    // R1 mode change ignored without clear
    mode = 1'b1; wt(6);
    chk("R1 ignored en", 32'(dout_en), 32'd0);
    check_all("R1");
    do_clear();
    check_all("R1 captured");

    // output mode
    do_cs(1'b0, 1'b1);
    do_strobe(8'hC3, 1'b0, 1'b0, 1'b0);
    chk("R7 load", 32'(dout), 32'hC3);
    chk("R6 en", 32'(dout_en), 32'd1);
    do_cs(1'b1, 1'b1);
    chk("R8 desel sets", 32'(srq), 32'd1);
    do_strobe(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R7 no load desel", 32'(dout), 32'hC3);
    chk("R8 fall clears", 32'(srq), 32'd0);
    do_cs(1'b0, 1'b1);
    do_strobe(8'h99, 1'b1, 1'b1, 1'b1);
    chk("R8 clear wins", 32'(srq), 32'd0);
    check_all("R8");

    // R9 clear while strobe high
    do_cs(1'b0, 1'b1);
    din = 8'hAA; stb = 1'b1; wt(5);
    chk("R7 live", 32'(dout), 32'hAA);
    clear = 1'b1; wt(1);
    chk("R9 strobe dout", 32'(dout), 32'd0);
    chk("R9 strobe srq",  32'(srq),  32'd0);
    stb = 1'b0; wt(2);
    clear = 1'b0;
    m_data = '0; m_flag = 1'b0; m_mode = mode; m_psel = fsel(m_mode, cs1, cs2);
    wt(6);
    check_all("R9 strobe");

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (i % 40 == 39) begin
        mode = 1'($urandom);
        do_clear();
        check_all("R9 rnd");
      end else if (r <= 2) begin
        do_cs(1'($urandom), 1'($urandom));
        check_all(m_mode ? "R8 rnd" : "R5 rnd");
      end else if (r <= 6) begin
        do_strobe(8'($urandom), 1'b0, 1'b0, 1'b0);
        check_all(m_mode ? "R7 rnd" : "R2 rnd");
      end else if (r <= 8) begin
        do_strobe(8'($urandom), 1'b1, 1'($urandom), 1'($urandom));
        check_all(m_mode ? "R8 rnd same" : "R3 rnd same");
      end else begin
        mode = 1'($urandom);
        wt(6);
        check_all("R1 rnd");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule